// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent virtual-to-physical page translations and answers lookups from a requester in one clock. Every entry is compared against the virtual page number (VPN) at the same time. A lookup presented in cycle t gives a registered answer in cycle t+1. On a hit, that answer is the stored physical page number (PPN) followed by the 12 low address bits, which are never translated because pages are 4 KB.

On a miss, the block routes the problem in one of two ways, chosen by an enable input. It can pulse a request to a hardware table walker, together with the missing VPN. It can instead raise a trap flag for software. In both cases it holds a stall flag toward the requester until a refill or a flush arrives. Refills come through one write port, whether a walker or software supplies them. A victim is chosen in this order: an entry that already holds the same VPN, then the lowest-numbered free entry, then a round-robin pointer. A single flush input empties the whole structure.

Top module: `xlat_cache`

## Requirements
- R1: On a lookup result, bits [11:0] of `lk_paddr` equal bits [11:0] of the virtual address looked up in the previous cycle.
- R2: On a hit, `lk_paddr[PA_W-1:12]` is the PPN stored for the looked-up VPN, presented one cycle after the request.
- R3: `lk_hit` and `lk_miss` are never both high. In the cycle after a lookup request exactly one of them is high. In the cycle after no request both are low.
- R4: When a miss occurs while `walk_en` was 1 at the request, `walk_req` pulses together with `lk_miss`, `walk_vpn` carries the missing VPN, and `sw_trap` stays low.
- R5: When a miss occurs while `walk_en` was 0 at the request, `sw_trap` pulses together with `lk_miss` and `walk_req` stays low.
- R6: `stall` rises with a miss. It stays high until the cycle after a refill or a flush. If a new miss occurs in the same cycle as that refill or flush, the new miss keeps `stall` high.
- R7: A refill takes effect at the end of its cycle. A lookup in the same cycle sees the old contents. A lookup of that VPN in the following cycle hits with the new PPN.
- R8: A refill whose VPN is already present overwrites that entry, so no duplicate is created and all other entries are kept.
- R9: A refill into a table with no matching VPN uses the lowest-numbered free entry. When every entry is valid it uses a round-robin pointer. That pointer starts at entry 0 after reset, advances by one (wrapping) only on such full-table refills, and is not changed by a flush.
- R10: `flush` invalidates every entry in one cycle. A refill in the same cycle as a flush is discarded.
- R11: After reset the table is empty and `lk_hit`, `lk_miss`, `walk_req`, `sw_trap` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Registered: previous lookup hit |
| lk_miss | output | 1 | Registered: previous lookup missed |
| lk_paddr | output | PA_W | Registered physical address (PPN and offset) |
| walk_en | input | 1 | 1 sends misses to the hardware walker, 0 sends them to software |
| walk_req | output | 1 | Pulse: walker should fetch `walk_vpn` |
| walk_vpn | output | VA_W-12 | VPN of the last miss |
| sw_trap | output | 1 | Pulse: software must handle the miss |
| stall | output | 1 | Requester must hold while a miss is outstanding |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | VA_W-12 | Refill virtual page number |
| fill_ppn | input | PA_W-12 | Refill physical page number |
| flush | input | 1 | Invalidate every entry |

## Verification
The bound assertions check on every cycle the relations that can be seen at the ports alone. These are: exclusivity and presence of hit and miss, pass-through of the offset, routing of a miss to exactly one of walker or trap with the correct VPN, raising and release of the stall, a refill becoming visible the next cycle, and a flush emptying the table. The choice of victim, overwriting of duplicates, the round-robin order once the table is full, and the loss of a refill that coincides with a flush all depend on the history of the table. Only the bench's reference model shows these, through later lookups that hit or miss. Directed sequences fill past capacity and test the colliding cases, and a seeded random mix covers the rest.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // where a refill slot comes from
  typedef enum logic [1:0] {
    VSRC_DUP  = 2'd0,
    VSRC_FREE = 2'd1,
    VSRC_RR   = 2'd2
  } vsrc_e;

  localparam int unsigned PAGE_OFF_W = 12;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic [VPN_W-1:0]   probe_vpn,
  output logic [ENTRIES-1:0] look_match,
  output logic [PPN_W-1:0]   look_ppn,
  output logic [ENTRIES-1:0] probe_match,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        valid_vec[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        valid_vec[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && !clr && wr_idx == IDX_W'(g)) begin
        tag_q[g] <= wr_vpn;
        ppn_q[g] <= wr_ppn;
      end
    end

    assign look_match[g]  = valid_vec[g] && (tag_q[g] == look_vpn);
    assign probe_match[g] = valid_vec[g] && (tag_q[g] == probe_vpn);
  end

  // at most one entry matches, so an OR of gated values selects it
  always_comb begin
    look_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      look_ppn = look_ppn | (look_match[i] ? ppn_q[i] : '0);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  vsrc_e            src;

  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_vec[i]) dup_idx = IDX_W'(i);
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (|dup_vec)      src = VSRC_DUP;
    else if (any_free) src = VSRC_FREE;
    else               src = VSRC_RR;
  end

  always_comb begin
    unique case (src)
      VSRC_DUP:  victim_idx = dup_idx;
      VSRC_FREE: victim_idx = free_idx;
      default:   victim_idx = rr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (commit && src == VSRC_RR) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned VPN_W  = VA_W - PAGE_OFF_W,
  localparam int unsigned PPN_W  = PA_W - PAGE_OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             walk_en,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             sw_trap,
  output logic             stall,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush
);

  logic [VPN_W-1:0]   look_vpn;
  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] probe_match;
  logic [ENTRIES-1:0] valid_vec;
  logic [PPN_W-1:0]   look_ppn;
  logic [IDX_W-1:0]   victim_idx;
  logic               commit;
  logic               hit_now;
  logic               miss_now;

  assign look_vpn = lk_vaddr[VA_W-1:PAGE_OFF_W];
  assign commit   = fill_valid && !flush;
  assign hit_now  = lk_valid && |look_match;
  assign miss_now = lk_valid && !(|look_match);

  xlat_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_cam (
    .clk         (clk),
    .rst         (rst),
    .clr         (flush),
    .wr_en       (commit),
    .wr_idx      (victim_idx),
    .wr_vpn      (fill_vpn),
    .wr_ppn      (fill_ppn),
    .look_vpn    (look_vpn),
    .probe_vpn   (fill_vpn),
    .look_match  (look_match),
    .look_ppn    (look_ppn),
    .probe_match (probe_match),
    .valid_vec   (valid_vec)
  );

  xlat_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .valid_vec  (valid_vec),
    .dup_vec    (probe_match),
    .victim_idx (victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      walk_req <= 1'b0;
      sw_trap  <= 1'b0;
      stall    <= 1'b0;
      lk_paddr <= '0;
      walk_vpn <= '0;
    end else begin
      lk_hit   <= hit_now;
      lk_miss  <= miss_now;
      walk_req <= miss_now && walk_en;
      sw_trap  <= miss_now && !walk_en;
      if (lk_valid) begin
        lk_paddr <= {look_ppn, lk_vaddr[PAGE_OFF_W-1:0]};
      end
      if (miss_now) begin
        walk_vpn <= look_vpn;
      end
      if (miss_now) begin
        stall <= 1'b1;
      end else if (fill_valid || flush) begin
        stall <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lk_valid,
  input logic [VA_W-1:0]       lk_vaddr,
  input logic                  lk_hit,
  input logic                  lk_miss,
  input logic [PA_W-1:0]       lk_paddr,
  input logic                  walk_en,
  input logic                  walk_req,
  input logic [VA_W-OFF_W-1:0] walk_vpn,
  input logic                  sw_trap,
  input logic                  stall,
  input logic                  fill_valid,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic [PA_W-OFF_W-1:0] fill_ppn,
  input logic                  flush
);

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst) !(lk_hit && lk_miss)); // R3
  AST_ANSWER_GIVEN: assert property (@(posedge clk) disable iff (rst) lk_valid |=> (lk_hit || lk_miss)); // R3
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> (!lk_hit && !lk_miss)); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst) lk_valid |=> lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])); // R1
  AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (rst) walk_req |-> (lk_miss && !sw_trap)); // R4
  AST_MISS_ROUTED: assert property (@(posedge clk) disable iff (rst) lk_miss |-> (walk_req || sw_trap)); // R4
  AST_WALK_VPN: assert property (@(posedge clk) disable iff (rst) lk_valid |=> (!walk_req || walk_vpn == $past(lk_vaddr[VA_W-1:OFF_W]))); // R4
  AST_TRAP_ON_MISS: assert property (@(posedge clk) disable iff (rst) sw_trap |-> lk_miss); // R5
  AST_WALKER_OFF: assert property (@(posedge clk) disable iff (rst) (lk_valid && !walk_en) |=> !walk_req); // R5
  AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (rst) lk_miss |-> stall); // R6
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst) ((fill_valid || flush) && !lk_valid) |=> !stall); // R6
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !flush) ##1 (lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))
    |=> (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn, 2))); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush ##1 lk_valid |=> lk_miss); // R10

endmodule

bind xlat_cache xlat_cache_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (xlat_pkg::PAGE_OFF_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_paddr   (lk_paddr),
  .walk_en    (walk_en),
  .walk_req   (walk_req),
  .walk_vpn   (walk_vpn),
  .sw_trap    (sw_trap),
  .stall      (stall),
  .fill_valid (fill_valid),
  .fill_vpn   (fill_vpn),
  .fill_ppn   (fill_ppn),
  .flush      (flush)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int N    = 16;
  localparam int VW   = VA_W - 12;
  localparam int PW   = PA_W - 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic          lk_hit, lk_miss, walk_req, sw_trap, stall;
  logic [PA_W-1:0] lk_paddr;
  logic [VW-1:0] walk_vpn;
  logic          walk_en = 1'b1;
  logic          fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic          flush = 1'b0;

  always #5 clk = ~clk;

  xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .walk_en(walk_en), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .sw_trap(sw_trap), .stall(stall), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model
  logic          m_v   [N];
  logic [VW-1:0] m_vpn [N];
  logic [PW-1:0] m_ppn [N];
  int            m_rr;
  logic          m_st;

  task automatic chk(input bit ok, input string req, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  task automatic step(input bit lv, input logic [VA_W-1:0] va, input bit we,
                      input bit fv, input logic [VW-1:0] fvpn, input logic [PW-1:0] fppn,
                      input bit fl, input string tag);
    bit found;
    logic [PW-1:0] e_ppn;
    bit e_hit, e_miss;
    int slot;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; walk_en = we;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; flush = fl;
    found = 1'b0; e_ppn = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == va[VA_W-1:12]) begin found = 1'b1; e_ppn = m_ppn[i]; end
    e_hit  = lv && found;
    e_miss = lv && !found;
    if (e_miss) m_st = 1'b1;
    else if (fv || fl) m_st = 1'b0;
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (fv) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (slot < 0 && m_v[i] && m_vpn[i] == fvpn) slot = i;
      for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
      m_v[slot] = 1'b1; m_vpn[slot] = fvpn; m_ppn[slot] = fppn;
    end
    @(posedge clk); #1;
    chk(lk_hit == e_hit, "R3", tag, 64'(lk_hit), 64'(e_hit));
    chk(lk_miss == e_miss, "R3", tag, 64'(lk_miss), 64'(e_miss));
    chk(walk_req == (e_miss && we), "R4", tag, 64'(walk_req), 64'(e_miss && we));
    chk(sw_trap == (e_miss && !we), "R5", tag, 64'(sw_trap), 64'(e_miss && !we));
    chk(stall == m_st, "R6", tag, 64'(stall), 64'(m_st));
    if (lv) chk(lk_paddr[11:0] == va[11:0], "R1", tag, 64'(lk_paddr[11:0]), 64'(va[11:0]));
    if (e_hit) chk(lk_paddr[PA_W-1:12] == e_ppn, "R2", tag, 64'(lk_paddr[PA_W-1:12]), 64'(e_ppn));
    if (e_miss && we) chk(walk_vpn == va[VA_W-1:12], "R4", tag, 64'(walk_vpn), 64'(va[VA_W-1:12]));
  endtask

  function automatic logic [VA_W-1:0] mkva(input logic [VW-1:0] v, input logic [11:0] o);
    return {v, o};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [VW-1:0] base;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; end
    m_rr = 0; m_st = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11 reset state
    chk(!lk_hit && !lk_miss && !walk_req && !sw_trap && !stall, "R11", "reset",
        {59'd0, lk_hit, lk_miss, walk_req, sw_trap, stall}, 64'd0);
    step(1, mkva(20'h00123, 12'h456), 1, 0, '0, '0, 0, "R11 empty lookup");

    // R7 lookup together with refill sees old contents, next cycle hits
    step(1, mkva(20'h12345, 12'hABC), 1, 1, 20'h12345, 20'h0BEEF, 0, "R7 same cycle");
    step(1, mkva(20'h12345, 12'h001), 1, 0, '0, '0, 0, "R7 next cycle");
    // R8 overwrite existing VPN
    step(0, '0, 1, 1, 20'h12345, 20'h0CAFE, 0, "R8 rewrite");
    step(1, mkva(20'h12345, 12'hFFF), 1, 0, '0, '0, 0, "R8 new ppn");
    // R5 software trap path
    step(1, mkva(20'h77777, 12'h010), 0, 0, '0, '0, 0, "R5 trap");
    step(0, '0, 0, 1, 20'h77777, 20'h00077, 0, "R6 release");
    step(1, mkva(20'h77777, 12'h020), 0, 0, '0, '0, 0, "R6 after fill");

    // R9 fill beyond capacity, round-robin eviction
    step(0, '0, 1, 0, '0, '0, 1, "R10 flush");
    base = 20'h40000;
    for (int i = 0; i < N + 3; i++)
      step(0, '0, 1, 1, base + VW'(i), PW'(i + 100), 0, "R9 fill");
    for (int i = 0; i < N + 3; i++)
      step(1, mkva(base + VW'(i), 12'(i)), 1, 0, '0, '0, 0, "R9 probe");

    // R10 flush discards a same-cycle refill
    step(0, '0, 1, 1, 20'h55555, 20'h00055, 1, "R10 flush+fill");
    step(1, mkva(20'h55555, 12'h0), 1, 0, '0, '0, 0, "R10 after flush");
    step(1, mkva(base + 3, 12'h0), 1, 0, '0, '0, 0, "R10 table empty");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [VW-1:0] v;
      v = 20'h80000 | VW'($urandom_range(0, 31));
      step($urandom_range(0, 9) < 8, mkva(v, 12'($urandom)), $urandom_range(0, 1) == 1,
           $urandom_range(0, 9) < 3, 20'h80000 | VW'($urandom_range(0, 31)), PW'($urandom),
           $urandom_range(0, 49) == 0, "R2 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule